// File: doc/BRIEF.md
# Dual-Tone Quadrature FSK Energy Detector

This block takes a stream of signed 16-bit audio samples and decides, once per output period, which of two tones is present. It runs two noncoherent branches, one tuned to the mark tone (a 1, 4450 Hz by default) and one to the space tone (a 0, 4050 Hz by default). Each branch multiplies the input by its own cosine and sine references to produce I and Q lanes. Each of the four lanes is low-pass filtered by a cascade of two decimating filters: a wide stage that decimates by 16 and a narrow stage that decimates by 8.

The block then computes I²+Q² for each branch, without a square root. It reports the bit decision and the larger of the two energies as a level indicator. Everything runs on one system clock. Input samples are marked by a valid strobe at the sample rate, nominally 200 kHz. Results are marked by a single-cycle strobe at 1/128 of the accepted sample rate. Each filter uses a single multiply-accumulate unit that is shared in time over its taps.

Top module: `fsk_tone_detector`

## Requirements
- R1: While reset is high and after it is released, out_valid, out_bit and out_mag are all 0 until the first result.
- R2: Each branch has a 16-bit phase that starts at 0 after reset and advances once per accepted sample by round(f·65536/Fs): 1458 for mark and 1327 for space at the defaults. Sample n uses the phase before its own step. The waveform is W(p) with x = p mod 32768 and m = min(32767, floor(x·(32768−x)/8192)); W(p) is m, negated when p ≥ 32768. The sine reference is W(p) and the cosine reference is W((p+16384) mod 65536).
- R3: For each branch, I = floor((x·cos + 16384)/32768) and Q = floor((x·sin + 16384)/32768), where x is the input sample.
- R4: The first filter stage on each lane forms the sum of w(k)·d(k) over k = 0..95, where d(0) is the newest product and w(k) = min(k+1, 96−k). It makes one output on every 16th product: the 16th, the 32nd, and so on. Each output is floor((sum + 2^11)/2^12). History before reset counts as zero.
- R5: The second stage applies the same rule to first-stage outputs, with 80 taps, w(k) = min(k+1, 80−k), one output on every 8th input, and a rounding shift of 11.
- R6: Branch energy is the exact value I²+Q² of the second-stage outputs, held as a 32-bit unsigned value, with no square root.
- R7: out_bit is 1 exactly when the mark energy is strictly greater than the space energy. A tie, including silence, gives 0.
- R8: out_mag equals the larger of the two energies, or their common value when they are equal.
- R9: out_valid is a single-cycle pulse. It appears once for every 128 accepted samples: after the 128th, the 256th, and so on. It comes no later than 300 cycles after that sample, and at no other time.
- R10: A sample is taken only in a cycle with in_valid high. Consecutive samples must be at least 8 cycles apart. Results do not depend on the actual spacing.
- R11: Results stay exact for full-scale input, including −32768, with no wrap anywhere in the datapath.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks a cycle that carries an input sample |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Single-cycle strobe marking a result |
| out_bit | output | 1 | Decision: 1 for mark, 0 for space or tie |
| out_mag | output | 32 | Larger branch energy (I²+Q²) |

## Verification
A new input sample can arrive in the same cycle that a filter's shared multiply-accumulate is partway through its sum. The history then shifts under the running sum, and the read offset must follow it. The stimulus provokes this collision on every first-stage output by spacing samples 8 cycles apart, shorter than the 96-cycle sum. A later pattern uses irregular spacing to sweep the collision across every tap position. Each result is judged bit-exactly against a behavioural model that has no notion of timing, so any misplaced tap shows up in out_mag.

// File: rtl/fsk_pkg.sv
package fsk_pkg;
    localparam int SAMPLE_W = 16;
    localparam int PHASE_W  = 16;
    localparam int PROD_W   = 2 * SAMPLE_W;
    localparam int ENERGY_W = 32;
    localparam int LANES    = 4;   // lane = 2*branch + (0:I, 1:Q); branch 0 space, 1 mark

    typedef logic signed [SAMPLE_W-1:0] sample_t;
    typedef logic [PHASE_W-1:0]         phase_t;

    typedef struct packed {
        logic                mark;
        logic [ENERGY_W-1:0] mag;
    } verdict_t;

    // phase step for a tone, rounded to nearest
    function automatic phase_t phase_step(input int f_hz, input int fs_hz);
        longint num;
        num = longint'(f_hz) * 65536 + longint'(fs_hz / 2);
        return PHASE_W'(num / longint'(fs_hz));
    endfunction

    // parabolic sine-like waveform from a 16-bit phase
    function automatic sample_t wave_of(input phase_t ph);
        logic [14:0] x;
        logic [15:0] rest;
        logic [30:0] t;
        logic [14:0] a;
        sample_t     s;
        x    = ph[14:0];
        rest = 16'd32768 - {1'b0, x};
        t    = 31'(x) * 31'(rest);
        a    = (t[30:13] > 18'd32767) ? 15'h7fff : t[27:13];
        s    = sample_t'({1'b0, a});
        return ph[15] ? -s : s;
    endfunction

    function automatic sample_t round_prod(input logic signed [PROD_W-1:0] p);
        logic signed [PROD_W-1:0] t;
        t = (p + (PROD_W'(1) <<< (SAMPLE_W - 2))) >>> (SAMPLE_W - 1);
        return t[SAMPLE_W-1:0];
    endfunction

    function automatic int tri_weight(input int k, input int taps);
        return (k + 1 < taps - k) ? k + 1 : taps - k;
    endfunction

    function automatic int tri_sum(input int taps);
        int s;
        s = 0;
        for (int k = 0; k < taps; k++) s += tri_weight(k, taps);
        return s;
    endfunction
endpackage

// File: rtl/fsk_nco_mixer.sv
module fsk_nco_mixer
    import fsk_pkg::*;
#(
    parameter phase_t STEP = 16'd1458
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_data,
    output logic    mix_valid,
    output sample_t mix_i,
    output sample_t mix_q
);
    localparam phase_t QUARTER = phase_t'(1) << (PHASE_W - 2);

    phase_t                   phase;
    sample_t                  sin_v, cos_v;
    logic signed [PROD_W-1:0] p_i, p_q;

    assign sin_v = wave_of(phase);
    assign cos_v = wave_of(phase + QUARTER);
    assign p_i   = PROD_W'(in_data) * PROD_W'(cos_v);
    assign p_q   = PROD_W'(in_data) * PROD_W'(sin_v);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= '0;
            mix_valid <= 1'b0;
            mix_i     <= '0;
            mix_q     <= '0;
        end else begin
            mix_valid <= in_valid;
            if (in_valid) begin
                phase <= phase + STEP;
                mix_i <= round_prod(p_i);
                mix_q <= round_prod(p_q);
            end
        end
    end

    // R2
    phase_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(phase));
endmodule

// File: rtl/fsk_decim_fir.sv
module fsk_decim_fir
    import fsk_pkg::*;
#(
    parameter int TAPS = 96,
    parameter int DEC  = 16
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    in_valid,
    input  sample_t in_data,
    output logic    out_valid,
    output sample_t out_data
);
    localparam int DEPTH = TAPS + DEC;
    localparam int AIW   = $clog2(DEPTH);
    localparam int AIW1  = AIW + 1;
    localparam int IXW   = $clog2(TAPS);
    localparam int CNW   = $clog2(DEC);
    localparam int CNW1  = CNW + 1;
    localparam int WSUM  = tri_sum(TAPS);
    localparam int SH    = $clog2(WSUM);
    localparam int AW    = SAMPLE_W + SH + 1;

    sample_t               hist [DEPTH];
    logic [CNW-1:0]        cnt;
    logic                  busy;
    logic [IXW-1:0]        idx;
    logic [CNW:0]          lag;    // samples shifted in since the sum started
    logic [AIW:0]          rd;
    logic                  trig;
    logic signed [AW-1:0]  acc, prod, acc_next, rounded;

    assign trig     = in_valid && (cnt == CNW'(DEC - 1));
    assign rd       = AIW1'(idx) + AIW1'(lag);
    assign prod     = AW'(hist[rd[AIW-1:0]]) * AW'(tri_weight(int'(idx), TAPS));
    assign acc_next = acc + prod;
    assign rounded  = (acc_next + (AW'(1) <<< (SH - 1))) >>> SH;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt       <= '0;
            busy      <= 1'b0;
            idx       <= '0;
            lag       <= '0;
            acc       <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            for (int k = 0; k < DEPTH; k++) hist[k] <= '0;
        end else begin
            out_valid <= 1'b0;
            if (in_valid) begin
                hist[0] <= in_data;
                for (int k = 1; k < DEPTH; k++) hist[k] <= hist[k-1];
                cnt <= trig ? '0 : cnt + 1'b1;
            end
            if (trig) begin
                busy <= 1'b1;
                idx  <= '0;
                lag  <= '0;
                acc  <= '0;
            end else if (busy) begin
                acc <= acc_next;
                lag <= lag + CNW1'(in_valid);
                if (idx == IXW'(TAPS - 1)) begin
                    busy      <= 1'b0;
                    out_valid <= 1'b1;
                    out_data  <= rounded[SAMPLE_W-1:0];
                end else begin
                    idx <= idx + 1'b1;
                end
            end
        end
    end

    // R10
    trig_idle_chk: assert property (@(posedge clk) disable iff (rst)
        trig |-> !busy);
    // R10
    read_range_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (rd < AIW1'(DEPTH)));
    // R9
    fir_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

// File: rtl/fsk_energy_cmp.sv
module fsk_energy_cmp
    import fsk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [LANES-1:0] lane_valid,
    input  sample_t          lane [LANES],
    output logic             res_valid,
    output verdict_t         res
);
    logic signed [PROD_W-1:0] sq [LANES];
    logic [ENERGY_W-1:0]      e_space, e_mark;

    always_comb begin
        for (int c = 0; c < LANES; c++) sq[c] = PROD_W'(lane[c]) * PROD_W'(lane[c]);
        e_space = $unsigned(sq[0]) + $unsigned(sq[1]);
        e_mark  = $unsigned(sq[2]) + $unsigned(sq[3]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res       <= '0;
        end else begin
            res_valid <= lane_valid[0];
            if (lane_valid[0]) begin
                res.mark <= e_mark > e_space;
                res.mag  <= (e_mark > e_space) ? e_mark : e_space;
            end
        end
    end

    // R9
    lane_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (|lane_valid) |-> (&lane_valid));
    // R7
    mark_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res.mark) |-> (res.mag != '0));
endmodule

// File: rtl/fsk_tone_detector.sv
module fsk_tone_detector
    import fsk_pkg::*;
#(
    parameter int FS_HZ    = 200000,
    parameter int MARK_HZ  = 4450,
    parameter int SPACE_HZ = 4050,
    parameter int TAPS1    = 96,
    parameter int DEC1     = 16,
    parameter int TAPS2    = 80,
    parameter int DEC2     = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic signed [15:0] in_sample,
    output logic        out_valid,
    output logic        out_bit,
    output logic [31:0] out_mag
);
    localparam phase_t MARK_STEP  = phase_step(MARK_HZ, FS_HZ);
    localparam phase_t SPACE_STEP = phase_step(SPACE_HZ, FS_HZ);

    sample_t          mix_lane [LANES];
    logic [1:0]       mix_v;
    sample_t          s1_d [LANES];
    sample_t          s2_d [LANES];
    logic [LANES-1:0] s1_v, s2_v;
    verdict_t         verdict;

    for (genvar b = 0; b < 2; b++) begin : g_branch
        fsk_nco_mixer #(.STEP(b == 1 ? MARK_STEP : SPACE_STEP)) u_mix (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (in_valid),
            .in_data   (in_sample),
            .mix_valid (mix_v[b]),
            .mix_i     (mix_lane[2*b]),
            .mix_q     (mix_lane[2*b+1])
        );
    end

    for (genvar c = 0; c < LANES; c++) begin : g_lane
        fsk_decim_fir #(.TAPS(TAPS1), .DEC(DEC1)) u_wide (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (mix_v[c/2]),
            .in_data   (mix_lane[c]),
            .out_valid (s1_v[c]),
            .out_data  (s1_d[c])
        );
        fsk_decim_fir #(.TAPS(TAPS2), .DEC(DEC2)) u_narrow (
            .clk       (clk),
            .rst       (rst),
            .in_valid  (s1_v[c]),
            .in_data   (s1_d[c]),
            .out_valid (s2_v[c]),
            .out_data  (s2_d[c])
        );
    end

    fsk_energy_cmp u_cmp (
        .clk        (clk),
        .rst        (rst),
        .lane_valid (s2_v),
        .lane       (s2_d),
        .res_valid  (out_valid),
        .res        (verdict)
    );

    assign out_bit = verdict.mark;
    assign out_mag = verdict.mag;

    // R9
    out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);
endmodule

// File: tb/fsk_tone_detector_bench.sv
module fsk_tone_detector_bench;
    localparam int CLK_PERIOD = 10;
    localparam int FS = 200000, MARKF = 4450, SPACEF = 4050;
    localparam int T1 = 96, D1 = 16, T2 = 80, D2 = 8;
    localparam int MAX_LAT = 300;
    localparam int MAXE = 256;
    localparam longint WD_CYCLES = 195000;
    localparam real PI2 = 6.283185307179586;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic signed [15:0] in_sample = '0;
    logic out_valid, out_bit;
    logic [31:0] out_mag;

    always #(CLK_PERIOD/2) clk = ~clk;

    fsk_tone_detector u_fsk_tone_detector (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sample(in_sample),
        .out_valid(out_valid), .out_bit(out_bit), .out_mag(out_mag)
    );

    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // reference model state (written only by the stimulus process)
    int ph [2];
    int stp [2];
    int h1 [4][T1];
    int h2 [4][T2];
    int c1, c2;
    int sh1, sh2;
    bit     exp_b   [MAXE];
    longint exp_mag [MAXE];
    longint exp_cyc [MAXE];
    int     exp_tag [MAXE];
    string  exp_req [MAXE];
    int wr_n = 0;
    int cur_tag;
    string cur_req;
    bit done_stim = 1'b0;
    real tph = 0.0;

    function automatic int wave(int p);
        int x, m;
        longint t;
        x = p & 32767;
        t = longint'(x) * longint'(32768 - x);
        m = int'(t >>> 13);
        if (m > 32767) m = 32767;
        return ((p & 32768) != 0) ? -m : m;
    endfunction

    function automatic int rshift(longint v, int sh);
        return int'((v + (longint'(1) <<< (sh - 1))) >>> sh);
    endfunction

    function automatic int tw(int k, int taps);
        return (k + 1 < taps - k) ? k + 1 : taps - k;
    endfunction

    function automatic int tsum(int taps);
        int s = 0;
        for (int k = 0; k < taps; k++) s += tw(k, taps);
        return s;
    endfunction

    function automatic void model_sample(int x);
        int v [4];
        int y1 [4];
        int y2 [4];
        longint acc, es, em;
        for (int b = 0; b < 2; b++) begin
            v[2*b]   = rshift(longint'(x) * wave((ph[b] + 16384) & 65535), 15);
            v[2*b+1] = rshift(longint'(x) * wave(ph[b]), 15);
            ph[b] = (ph[b] + stp[b]) & 65535;
        end
        for (int c = 0; c < 4; c++) begin
            for (int k = T1 - 1; k > 0; k--) h1[c][k] = h1[c][k-1];
            h1[c][0] = v[c];
        end
        c1++;
        if (c1 == D1) begin
            c1 = 0;
            for (int c = 0; c < 4; c++) begin
                acc = 0;
                for (int k = 0; k < T1; k++) acc += longint'(tw(k, T1)) * h1[c][k];
                y1[c] = rshift(acc, sh1);
                for (int k = T2 - 1; k > 0; k--) h2[c][k] = h2[c][k-1];
                h2[c][0] = y1[c];
            end
            c2++;
            if (c2 == D2) begin
                c2 = 0;
                for (int c = 0; c < 4; c++) begin
                    acc = 0;
                    for (int k = 0; k < T2; k++) acc += longint'(tw(k, T2)) * h2[c][k];
                    y2[c] = rshift(acc, sh2);
                end
                es = longint'(y2[0]) * y2[0] + longint'(y2[1]) * y2[1];
                em = longint'(y2[2]) * y2[2] + longint'(y2[3]) * y2[3];
                if (wr_n < MAXE) begin
                    exp_b[wr_n]   = em > es;
                    exp_mag[wr_n] = (em > es) ? em : es;
                    exp_cyc[wr_n] = cyc;
                    exp_tag[wr_n] = cur_tag;
                    exp_req[wr_n] = cur_req;
                end
                wr_n++;
            end
        end
    endfunction

    // called at posedge+1; returns at posedge+1, gap cycles later
    task automatic send(int x, int gap);
        in_valid  = 1'b1;
        in_sample = 16'(x);
        model_sample(x);
        @(posedge clk); #1;
        in_valid = 1'b0;
        repeat (gap - 1) @(posedge clk);
        #1;
    endtask

    // mode 0 silence, 1 sine, 2 full-scale square; irregular adds 0..4 cycles of gap
    task automatic pattern(int mode, int f, int n, int amp, bit irregular, int tagv, string req);
        int x;
        real s;
        cur_req = req;
        for (int i = 0; i < n; i++) begin
            cur_tag = (i >= 1500) ? tagv : -1;
            if (mode == 0) cur_tag = tagv;
            s = $sin(tph);
            tph = tph + PI2 * f / FS;
            if (tph > PI2) tph = tph - PI2;
            if (mode == 0) x = 0;
            else if (mode == 1) x = int'(amp * s);
            else x = (s >= 0.0) ? 32767 : -32768;
            send(x, irregular ? 8 + (i % 5) : 8);
        end
    endtask

    initial begin
        stp[1] = int'((longint'(MARKF) * 65536 + FS / 2) / FS);
        stp[0] = int'((longint'(SPACEF) * 65536 + FS / 2) / FS);
        sh1 = $clog2(tsum(T1));
        sh2 = $clog2(tsum(T2));
        ph[0] = 0; ph[1] = 0; c1 = 0; c2 = 0;
        for (int c = 0; c < 4; c++) begin
            for (int k = 0; k < T1; k++) h1[c][k] = 0;
            for (int k = 0; k < T2; k++) h2[c][k] = 0;
        end
        cur_tag = -1;
        cur_req = "R1";
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        pattern(0, 0, 384, 0, 1'b0, 2, "R7");
        pattern(1, MARKF, 2560, 16000, 1'b0, 1, "R2 R8");
        pattern(1, SPACEF, 2560, 16000, 1'b0, 0, "R3");
        for (int b = 0; b < 3; b++) begin
            pattern(1, MARKF, 500, 12000, 1'b0, -1, "R4 R5");
            pattern(1, SPACEF, 500, 12000, 1'b0, -1, "R4 R5");
        end
        pattern(2, MARKF, 1536, 0, 1'b0, 1, "R11");
        pattern(1, SPACEF, 1280, 20000, 1'b1, 0, "R10");
        done_stim = 1'b1;
    end

    // all checking happens here
    int checks = 0, errors = 0;
    int rd_n = 0;
    int drain = 0;
    bit reset_checked = 1'b0;
    bit finished = 1'b0;

    task automatic report();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(negedge clk) begin
        if (!finished) begin
            if (cyc > WD_CYCLES) begin
                checks++; errors++;
                $display("FAIL R9 watchdog expired: got %0d results, expected %0d", rd_n, wr_n);
                finished = 1'b1;
                report();
            end else if (rst) begin
                // R1 during reset
                checks++;
                if (out_valid !== 1'b0 || out_bit !== 1'b0 || out_mag !== 32'd0) begin
                    errors++;
                    $display("FAIL R1 in reset: valid=%b bit=%b mag=%0d expected 0 0 0", out_valid, out_bit, out_mag);
                end
            end else begin
                if (!reset_checked) begin
                    reset_checked = 1'b1;
                    checks++;
                    if (out_valid !== 1'b0 || out_bit !== 1'b0 || out_mag !== 32'd0) begin
                        errors++;
                        $display("FAIL R1 after reset: valid=%b bit=%b mag=%0d expected 0 0 0", out_valid, out_bit, out_mag);
                    end
                end
                if (out_valid === 1'b1) begin
                    checks++;
                    if (rd_n >= wr_n || rd_n >= MAXE) begin
                        errors++;
                        $display("FAIL R9 unexpected out_valid: result %0d, expected only %0d", rd_n + 1, wr_n);
                    end else begin
                        checks++;
                        if (out_bit !== exp_b[rd_n]) begin
                            errors++;
                            $display("FAIL %s/R7 out_bit #%0d: got %b expected %b", exp_req[rd_n], rd_n, out_bit, exp_b[rd_n]);
                        end
                        checks++;
                        if (longint'(out_mag) != exp_mag[rd_n]) begin
                            errors++;
                            $display("FAIL %s/R6 out_mag #%0d: got %0d expected %0d", exp_req[rd_n], rd_n, out_mag, exp_mag[rd_n]);
                        end
                        checks++;
                        if (cyc - exp_cyc[rd_n] > MAX_LAT) begin
                            errors++;
                            $display("FAIL R9 latency #%0d: got %0d expected <= %0d", rd_n, cyc - exp_cyc[rd_n], MAX_LAT);
                        end
                        if (exp_tag[rd_n] >= 0) begin
                            checks++;
                            if (out_bit !== ((exp_tag[rd_n] == 1) ? 1'b1 : 1'b0)) begin
                                errors++;
                                $display("FAIL %s/R7 tone decision #%0d: got %b expected %0d", exp_req[rd_n], rd_n, out_bit, exp_tag[rd_n] == 1);
                            end
                        end
                        if (exp_tag[rd_n] == 2) begin
                            checks++;
                            if (out_mag !== 32'd0) begin
                                errors++;
                                $display("FAIL R8 silence magnitude #%0d: got %0d expected 0", rd_n, out_mag);
                            end
                        end
                    end
                    rd_n++;
                end
                if (done_stim) begin
                    drain++;
                    if (drain == 400) begin
                        checks++;
                        if (rd_n != wr_n) begin
                            errors++;
                            $display("FAIL R9 result count: got %0d expected %0d", rd_n, wr_n);
                        end
                        finished = 1'b1;
                        report();
                    end
                end
            end
        end
    end
endmodule